// File: doc/BRIEF.md
# Three-Bus Arithmetic-Logic Unit with Immediate Conditioning

This block is the combinational arithmetic-logic unit of a 32-bit datapath that moves data over three buses. Two source buses feed it and it drives the destination bus in the same cycle. A one-hot function select picks one of eight functions: pass-through of the first or the second source, add, subtract, bitwise AND, OR, XOR, and bitwise complement of the second source. Increment and decrement are add or subtract with a constant 1 on the second source. Negation is subtract with a constant zero on the first source.

The first source bus can carry a 20-bit immediate field. An immediate-enable input conditions that bus before any function sees it. The upper bits are replaced by zeros, or by copies of bit 19 when sign extension is also requested. The block also produces negative, zero, overflow and carry flags for the program status register.

Top module: `alu3bus`

## Requirements
- R1: With only function-select bit 0 set, the result equals the conditioned first operand (see R6 to R8).
- R2: With only function-select bit 1 set, the result equals the second source bus unchanged.
- R3: Bit 2 selects the sum of the conditioned first operand and the second source. Bit 3 selects the conditioned first operand minus the second source. Both are modulo 2^32, so increment, decrement and negation (0 minus x) follow.
- R4: Bits 4, 5 and 6 select bitwise AND, OR and XOR of the conditioned first operand and the second source.
- R5: Bit 7 selects the bitwise complement of the second source bus.
- R6: With immediate-enable and sign-extend both high, the first operand is bits 19..0 of the first bus, with bits 31..20 all copies of bit 19.
- R7: With immediate-enable high and sign-extend low, the first operand is bits 19..0 of the first bus, with bits 31..20 zero.
- R8: With immediate-enable low, the first bus is used unchanged and sign-extend has no effect on the result or the flags.
- R9: With no function-select bit set, the result is zero.
- R10: When several function-select bits are set, the lowest-numbered set bit alone determines the function.
- R11: The negative flag equals result bit 31 and the zero flag is high exactly when the result is zero, for every function.
- R12: For add, carry is the carry out of bit 31. For subtract, carry is 1 exactly when there is no unsigned borrow (first operand >= second). For both, overflow is high on two's-complement overflow. For every other function, and with no function, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| b1 | input | 32 | First source bus; bits 19..0 form the immediate field |
| b2 | input | 32 | Second source bus |
| func_sel | input | 8 | One-hot function select, lowest set bit wins |
| imm_en | input | 1 | Treat b1 as a 20-bit immediate field |
| imm_sext | input | 1 | Sign-extend the immediate instead of zero-filling |
| b3 | output | 32 | Destination bus |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |
| flag_v | output | 1 | Signed overflow of add or subtract |
| flag_c | output | 1 | Carry out of add, or no-borrow of subtract |

## Verification
Immediate conditioning and an arithmetic function act together in the same cycle. This matters most for add with a sign-extended negative immediate, where the extended upper bits decide the carry and overflow flags. Two function-select bits can also be asserted at once. The bench provokes both cases: random stimulus sets several select bits together and varies both immediate controls, and directed cases pair add with subtract and the first pass-through with complement. An independent model in the bench judges the result and all four flags, and from the lowest set bit it predicts which function wins.

// File: rtl/alu3bus_pkg.sv
package alu3bus_pkg;
   localparam int FN_COUNT = 8;
   localparam int FN_IDX_W = $clog2(FN_COUNT);

   typedef enum logic [FN_IDX_W-1:0] {
      OP_PASS_A = 3'd0,
      OP_PASS_B = 3'd1,
      OP_ADD    = 3'd2,
      OP_SUB    = 3'd3,
      OP_AND    = 3'd4,
      OP_OR     = 3'd5,
      OP_XOR    = 3'd6,
      OP_INV_B  = 3'd7
   } alu_op_e;
endpackage

// File: rtl/alu3bus_opnd.sv
// Conditions the first source bus when it carries an immediate field (R6, R7, R8).
module alu3bus_opnd #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 20
) (
   input  logic [WIDTH-1:0] raw,
   input  logic             imm_en,
   input  logic             imm_sext,
   output logic [WIDTH-1:0] cond
);
   localparam int HI_W = WIDTH - IMM_W;

   logic fill;

   always_comb begin
      fill = imm_sext & raw[IMM_W-1];
      if (imm_en) cond = {{HI_W{fill}}, raw[IMM_W-1:0]};
      else        cond = raw;
   end
endmodule

// File: rtl/alu3bus_sel.sv
// Priority decode of the one-hot select: lowest set bit wins (R10).
module alu3bus_sel
   import alu3bus_pkg::*;
#(
   parameter int NFN = FN_COUNT
) (
   input  logic [NFN-1:0] func_sel,
   output alu_op_e        op,
   output logic           any
);
   always_comb begin
      op  = OP_PASS_A;
      any = 1'b0;
      for (int i = NFN - 1; i >= 0; i--) begin
         if (func_sel[i]) begin
            op  = alu_op_e'(i[FN_IDX_W-1:0]);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/alu3bus_arith.sv
// Shared adder/subtractor with carry and overflow (R3, R12).
module alu3bus_arith #(
   parameter int WIDTH      = 32,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] bx;

   assign bx = b ^ {WIDTH{sub}};

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = sub;
         for (genvar k = 0; k < WIDTH; k++) begin : g_cell
            assign sum[k]  = a[k] ^ bx[k] ^ cy[k];
            assign cy[k+1] = (a[k] & bx[k]) | (cy[k] & (a[k] ^ bx[k]));
         end
         assign cout = cy[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, a} + {1'b0, bx} + {{WIDTH{1'b0}}, sub};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   assign ovf = (a[MSB] == bx[MSB]) & (sum[MSB] ^ a[MSB]);
endmodule

// File: rtl/alu3bus.sv
module alu3bus
   import alu3bus_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter int IMM_W      = 20,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic [WIDTH-1:0]    b1,
   input  logic [WIDTH-1:0]    b2,
   input  logic [FN_COUNT-1:0] func_sel,
   input  logic                imm_en,
   input  logic                imm_sext,
   output logic [WIDTH-1:0]    b3,
   output logic                flag_n,
   output logic                flag_z,
   output logic                flag_v,
   output logic                flag_c
);
   generate
      if (IMM_W < 1 || IMM_W >= WIDTH) begin : g_bad_imm
         $error("alu3bus: IMM_W must lie in 1..WIDTH-1");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("alu3bus: WIDTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] opa;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;
   logic             any;
   alu_op_e          op;

   alu3bus_opnd #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opnd (
      .raw(b1), .imm_en(imm_en), .imm_sext(imm_sext), .cond(opa)
   );

   alu3bus_sel #(.NFN(FN_COUNT)) u_sel (
      .func_sel(func_sel), .op(op), .any(any)
   );

   alu3bus_arith #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) u_arith (
      .a(opa), .b(b2), .sub(op == OP_SUB), .sum(sum), .cout(cout), .ovf(ovf)
   );

   always_comb begin
      b3     = '0;
      flag_v = 1'b0;
      flag_c = 1'b0;
      if (any) begin
         unique case (op)
            OP_PASS_A: b3 = opa;
            OP_PASS_B: b3 = b2;
            OP_ADD, OP_SUB: begin
               b3     = sum;
               flag_v = ovf;
               flag_c = cout;
            end
            OP_AND:   b3 = opa & b2;
            OP_OR:    b3 = opa | b2;
            OP_XOR:   b3 = opa ^ b2;
            OP_INV_B: b3 = ~b2;
            default:  b3 = '0;
         endcase
      end
      flag_n = b3[WIDTH-1];
      flag_z = (b3 == '0);
   end
endmodule

// File: rtl/alu3bus_chk.sv
module alu3bus_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] b1,
   input logic [WIDTH-1:0] b2,
   input logic [7:0]       func_sel,
   input logic             imm_en,
   input logic             imm_sext,
   input logic [WIDTH-1:0] b3,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_v,
   input logic             flag_c
);
   logic arith_wins;
   assign arith_wins = (func_sel[1:0] == 2'b00) && (func_sel[3:2] != 2'b00);

   always_comb begin
      p_idle_zero_r9: assert (func_sel != 8'h00 || (b3 == '0 && flag_z));
      p_zero_flag_r11: assert (flag_z == (b3 == '0));
      p_neg_flag_r11: assert (flag_n == b3[WIDTH-1]);
      p_flags_quiet_r12: assert (arith_wins || (!flag_v && !flag_c));
      p_pass_b_r2: assert (func_sel != 8'h02 || b3 == b2);
      p_invert_r5: assert (func_sel != 8'h80 || b3 == ~b2);
      p_pass_raw_r8: assert (func_sel != 8'h01 || imm_en || b3 == b1);
   end
endmodule

bind alu3bus alu3bus_chk #(.WIDTH(WIDTH)) u_chk (
   .b1(b1), .b2(b2), .func_sel(func_sel), .imm_en(imm_en), .imm_sext(imm_sext),
   .b3(b3), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/alu3bus_test.sv
module alu3bus_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] b1 = '0, b2 = '0;
   logic [7:0]  func_sel = '0;
   logic        imm_en = 1'b0, imm_sext = 1'b0;
   logic [31:0] b3;
   logic        flag_n, flag_z, flag_v, flag_c;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   alu3bus uut (
      .b1(b1), .b2(b2), .func_sel(func_sel), .imm_en(imm_en), .imm_sext(imm_sext),
      .b3(b3), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   // Expected {n, z, v, c, result} from the requirements.
   function automatic logic [35:0] model(input logic [31:0] x, input logic [31:0] y,
                                         input logic [7:0] f, input logic ie, input logic se);
      logic [31:0] a, r;
      logic [32:0] w;
      logic v, c;
      int win;
      a = x;
      if (ie) a = {{12{se & x[19]}}, x[19:0]};
      win = -1;
      for (int i = 7; i >= 0; i--) if (f[i]) win = i;
      r = '0; v = 1'b0; c = 1'b0;
      case (win)
         0: r = a;
         1: r = y;
         2: begin
            w = {1'b0, a} + {1'b0, y};
            r = w[31:0]; c = w[32];
            v = (a[31] == y[31]) && (r[31] != a[31]);
         end
         3: begin
            r = a - y; c = (a >= y);
            v = (a[31] != y[31]) && (r[31] != a[31]);
         end
         4: r = a & y;
         5: r = a | y;
         6: r = a ^ y;
         7: r = ~y;
         default: r = '0;
      endcase
      return {r[31], (r == 32'd0), v, c, r};
   endfunction

   task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got nzvc=%b b3=%h expected nzvc=%b b3=%h",
                  tag, got[35:32], got[31:0], exp[35:32], exp[31:0]);
      end
   endtask

   task automatic apply(input string tag, input logic [31:0] x, input logic [31:0] y,
                        input logic [7:0] f, input logic ie, input logic se);
      @(negedge clk);
      b1 = x; b2 = y; func_sel = f; imm_en = ie; imm_sext = se;
      @(posedge clk);
      #1;
      check(tag, {flag_n, flag_z, flag_v, flag_c, b3}, model(x, y, f, ie, se));
   endtask

   // Explicit-value check so the bench does not rely only on its model.
   task automatic apply_lit(input string tag, input logic [31:0] x, input logic [31:0] y,
                            input logic [7:0] f, input logic ie, input logic se,
                            input logic [35:0] exp);
      @(negedge clk);
      b1 = x; b2 = y; func_sel = f; imm_en = ie; imm_sext = se;
      @(posedge clk);
      #1;
      check(tag, {flag_n, flag_z, flag_v, flag_c, b3}, exp);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state, no function selected
      check("R9 idle after reset", {flag_n, flag_z, flag_v, flag_c, b3}, {4'b0100, 32'h0});

      apply_lit("R1 pass first", 32'hDEAD_BEEF, 32'h1, 8'h01, 0, 0, {4'b1000, 32'hDEAD_BEEF});
      apply_lit("R2 pass second", 32'h1, 32'h0BAD_F00D, 8'h02, 0, 0, {4'b0000, 32'h0BAD_F00D});
      apply_lit("R3 R12 add overflow", 32'h7FFF_FFFF, 32'h1, 8'h04, 0, 0, {4'b1010, 32'h8000_0000});
      apply_lit("R3 R12 add carry to zero", 32'hFFFF_FFFF, 32'h1, 8'h04, 0, 0, {4'b0101, 32'h0});
      apply_lit("R3 R12 decrement borrow", 32'h0, 32'h1, 8'h08, 0, 0, {4'b1000, 32'hFFFF_FFFF});
      apply_lit("R3 R12 negate", 32'h0, 32'h5, 8'h08, 0, 0, {4'b1000, 32'hFFFF_FFFB});
      apply_lit("R3 R12 sub overflow", 32'h8000_0000, 32'h1, 8'h08, 0, 0, {4'b0011, 32'h7FFF_FFFF});
      apply_lit("R4 and", 32'hF0F0_1234, 32'hFF00_FF00, 8'h10, 0, 0, {4'b1000, 32'hF000_1200});
      apply_lit("R4 or", 32'h0000_00F0, 32'h0000_000F, 8'h20, 0, 0, {4'b0000, 32'h0000_00FF});
      apply_lit("R4 xor to zero", 32'h1234_5678, 32'h1234_5678, 8'h40, 0, 0, {4'b0100, 32'h0});
      apply_lit("R5 invert", 32'h1, 32'hFFFF_0000, 8'h80, 0, 0, {4'b0000, 32'h0000_FFFF});
      apply_lit("R6 sign extend", 32'h0008_0000, 32'h0, 8'h01, 1, 1, {4'b1000, 32'hFFF8_0000});
      apply_lit("R6 positive immediate", 32'hABC7_FFFF, 32'h0, 8'h01, 1, 1, {4'b0000, 32'h0007_FFFF});
      apply_lit("R7 zero extend", 32'hABC8_0001, 32'h0, 8'h01, 1, 0, {4'b0000, 32'h0008_0001});
      apply_lit("R6 R12 add negative imm", 32'h000F_FFFF, 32'h5, 8'h04, 1, 1, {4'b0001, 32'h4});
      apply_lit("R8 sext ignored", 32'h8008_0000, 32'h0, 8'h01, 0, 1, {4'b1000, 32'h8008_0000});
      apply_lit("R8 sext ignored add", 32'h0008_0000, 32'h1, 8'h04, 0, 1, {4'b0000, 32'h0008_0001});
      apply_lit("R9 no function", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00, 1, 1, {4'b0100, 32'h0});
      apply_lit("R10 add beats sub", 32'h3, 32'h1, 8'h0C, 0, 0, {4'b0000, 32'h4});
      apply_lit("R10 pass first beats invert", 32'h5, 32'h0, 8'h81, 0, 0, {4'b0000, 32'h5});
      apply_lit("R10 R12 xor beats invert, flags quiet", 32'hFFFF_FFFF, 32'h0, 8'hC0, 0, 0,
                {4'b1000, 32'hFFFF_FFFF});
      apply_lit("R11 R12 logic flags", 32'h0, 32'h0, 8'h10, 0, 0, {4'b0100, 32'h0});

      for (int n = 0; n < 3000; n++) begin
         logic [7:0] f;
         logic [31:0] x, y;
         f = 8'h1 << ($urandom % 8);
         if ($urandom % 4 == 0) f = 8'($urandom);
         x = $urandom;
         y = $urandom;
         if ($urandom % 8 == 0) y = x;
         if ($urandom % 8 == 0) x = 32'h7FFF_FFFF;
         apply("R1 R2 R3 R4 R5 R6 R7 R8 R10 R11 R12 random", x, y, f, 1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule